// File: doc/BRIEF.md
# Unaligned Region Chip-Select Decoder

This block turns a 16-bit address into one-hot chip selects for three 8 KB memory regions whose bases sit off the usual 8 KB grid. The addresses between region boundaries are all live, so a few high-order bits cannot do the job. The block compares the full address against each boundary using magnitude (less-than) comparators. The region that owns the address is the one whose lower boundary the address is not below, but whose upper boundary it is below.

For the selected region, the block also gives the offset of the address inside that region. The offset is the address minus the region base, truncated to 13 bits. Addresses outside all three regions raise an unmapped flag. The outputs come straight from the logic when `REGISTERED` is 0. When it is 1, the outputs pass through a flop stage with one cycle of latency and a synchronous active-high reset.

The four boundaries are parameters, and elaboration rejects them if they are not ascending or if a region spans more than 8 KB.

Top module: `ucs_decoder`

## Requirements
- R1: The select output `region_sel` is one bit per region: bit 0 is the RAM region, bit 1 is the first ROM region and bit 2 is the second ROM region. At most one bit is ever set.
- R2: `region_sel[0]` is set exactly when 6050h <= addr < 8050h (default boundaries).
- R3: `region_sel[1]` is set exactly when 8050h <= addr < A050h.
- R4: `region_sel[2]` is set exactly when A050h <= addr < C050h.
- R5: `unmapped` is 1 exactly when addr < 6050h or addr >= C050h, and then `region_sel` is 000.
- R6: When a region is selected, `offset` equals (addr minus that region's lower boundary) modulo 2^13.
- R7: When no region is selected, `offset` is 0.
- R8: A boundary address belongs to the region above it, and the address one below a boundary belongs to the region (or the unmapped space) below it. No address outside the three ranges selects a region, so there are no aliased copies.
- R9: With `REGISTERED`=1, every output equals the combinational result for the address presented one clock earlier.
- R10: With `REGISTERED`=1, a clock edge with `rst` high clears `region_sel` and `offset` and sets `unmapped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| addr | input | 16 | Bus address to decode |
| region_sel | output | 3 | One-hot region select (bit 0 RAM, 1 ROM1, 2 ROM2) |
| offset | output | 13 | Address minus the selected region base |
| unmapped | output | 1 | Address lies outside every region |

## Verification
The assertions assume that `addr` is a known value on every sampled edge and that the boundary parameters keep their defaults. The range and offset properties compare against those defaults. The stimulus drives every one of the 65536 addresses, always as a defined value, both through a combinational instance and through a registered instance. It returns to each boundary and to the addresses next to it for focused checks. Reset is applied to the registered instance only on clock edges chosen by the bench, after the pipeline has been filled with a mapped address.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
   localparam int unsigned ADDR_W    = 16;
   localparam int unsigned OFF_W     = 13;
   localparam int unsigned N_REGIONS = 3;
   localparam int unsigned N_BOUND   = N_REGIONS + 1;

   typedef logic [ADDR_W-1:0]    addr_t;
   typedef logic [OFF_W-1:0]     off_t;
   typedef logic [N_REGIONS-1:0] sel_t;

   typedef struct packed {
      sel_t sel;
      off_t off;
      logic unmapped;
   } decode_t;
endpackage

// File: rtl/ucs_below.sv
module ucs_below #(
   parameter int unsigned WIDTH = 16,
   parameter logic [WIDTH-1:0] LIMIT = '0
) (
   input  logic [WIDTH-1:0] value,
   output logic             below
);
   always_comb below = (value < LIMIT);
endmodule

// File: rtl/ucs_offset.sv
module ucs_offset #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned OFF_W   = 13,
   parameter int unsigned REGIONS = 3,
   parameter logic [WIDTH*(REGIONS+1)-1:0] BOUNDS = '0
) (
   input  logic [WIDTH-1:0]   value,
   input  logic [REGIONS-1:0] sel,
   output logic [OFF_W-1:0]   off
);
   logic [REGIONS-1:0][OFF_W-1:0] per_region;

   for (genvar g = 0; g < REGIONS; g++) begin : g_sub
      localparam logic [WIDTH-1:0] BASE = BOUNDS[g*WIDTH +: WIDTH];
      logic [WIDTH-1:0] diff;
      always_comb begin
         diff          = value - BASE;
         per_region[g] = sel[g] ? diff[OFF_W-1:0] : '0;
      end
   end

   always_comb begin
      off = '0;
      for (int i = 0; i < REGIONS; i++) off |= per_region[i];
   end
endmodule

// File: rtl/ucs_decoder.sv
module ucs_decoder #(
   parameter logic [15:0] BOUND0 = 16'h6050,
   parameter logic [15:0] BOUND1 = 16'h8050,
   parameter logic [15:0] BOUND2 = 16'hA050,
   parameter logic [15:0] BOUND3 = 16'hC050,
   parameter bit REGISTERED = 1'b0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [15:0] addr,
   output logic [2:0]  region_sel,
   output logic [12:0] offset,
   output logic        unmapped
);
   import ucs_pkg::*;

   localparam int unsigned SPAN_MAX = 1 << OFF_W;
   localparam logic [ADDR_W*N_BOUND-1:0] BOUNDS = {BOUND3, BOUND2, BOUND1, BOUND0};

   if (!(BOUND0 < BOUND1 && BOUND1 < BOUND2 && BOUND2 < BOUND3))
      $error("ucs_decoder: boundaries must ascend");
   if ((int'(BOUND1) - int'(BOUND0)) > SPAN_MAX ||
       (int'(BOUND2) - int'(BOUND1)) > SPAN_MAX ||
       (int'(BOUND3) - int'(BOUND2)) > SPAN_MAX)
      $error("ucs_decoder: a region exceeds the offset range");

   logic [N_BOUND-1:0] lt;
   sel_t    sel_c;
   off_t    off_c;
   decode_t dec_c;

   for (genvar b = 0; b < N_BOUND; b++) begin : g_cmp
      ucs_below #(.WIDTH(ADDR_W), .LIMIT(BOUNDS[b*ADDR_W +: ADDR_W])) u_cmp (
         .value (addr),
         .below (lt[b])
      );
   end

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_sel
      always_comb sel_c[r] = !lt[r] && lt[r+1];
   end

   ucs_offset #(
      .WIDTH(ADDR_W), .OFF_W(OFF_W), .REGIONS(N_REGIONS), .BOUNDS(BOUNDS)
   ) u_off (
      .value (addr),
      .sel   (sel_c),
      .off   (off_c)
   );

   always_comb begin
      dec_c.sel      = sel_c;
      dec_c.off      = off_c;
      dec_c.unmapped = lt[0] || !lt[N_BOUND-1];
   end

   decode_t dec_q;

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            dec_q.sel      <= '0;
            dec_q.off      <= '0;
            dec_q.unmapped <= 1'b1;
         end else begin
            dec_q <= dec_c;
         end
      end
   end else begin : g_comb
      always_comb dec_q = dec_c;
   end

   assign region_sel = dec_q.sel;
   assign offset     = dec_q.off;
   assign unmapped   = dec_q.unmapped;
endmodule

// File: rtl/ucs_decoder_chk.sv
module ucs_decoder_chk #(
   parameter bit REGISTERED = 1'b0
) (
   input logic        clk,
   input logic        rst,
   input logic [15:0] addr,
   input logic [2:0]  region_sel,
   input logic [12:0] offset,
   input logic        unmapped
);
   logic [15:0] ref_a;
   logic        ref_ok;
   logic        seen;

   if (REGISTERED) begin : g_ref_reg
      always_ff @(posedge clk) begin
         ref_a  <= addr;
         ref_ok <= !rst;
         seen   <= 1'b1;
      end
   end else begin : g_ref_comb
      always_comb begin
         ref_a  = addr;
         ref_ok = 1'b1;
         seen   = 1'b1;
      end
   end

   logic live;
   always_comb live = seen && ref_ok && !rst;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(region_sel)); // R1
   AST_RAM_RANGE: assert property (@(posedge clk) disable iff (rst)
      live |-> (region_sel[0] == (ref_a >= 16'h6050 && ref_a < 16'h8050))); // R2
   AST_ROM1_RANGE: assert property (@(posedge clk) disable iff (rst)
      live |-> (region_sel[1] == (ref_a >= 16'h8050 && ref_a < 16'hA050))); // R3
   AST_ROM2_RANGE: assert property (@(posedge clk) disable iff (rst)
      live |-> (region_sel[2] == (ref_a >= 16'hA050 && ref_a < 16'hC050))); // R4
   AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
      unmapped |-> (region_sel == 3'b000)); // R5
   AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (rst)
      (region_sel == 3'b000) |-> (offset == 13'd0)); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      (REGISTERED && $past(rst)) |-> (region_sel == 3'b000 && unmapped)); // R10
endmodule

bind ucs_decoder ucs_decoder_chk #(.REGISTERED(REGISTERED)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .addr       (addr),
   .region_sel (region_sel),
   .offset     (offset),
   .unmapped   (unmapped)
);

// File: tb/tb_ucs_decoder.sv
`timescale 1ns/1ps
module tb_ucs_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr = 16'h0000;
   logic [2:0]  sel_c, sel_r;
   logic [12:0] off_c, off_r;
   logic        un_c, un_r;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ucs_decoder #(.REGISTERED(1'b0)) dut (
      .clk(clk), .rst(rst), .addr(addr),
      .region_sel(sel_c), .offset(off_c), .unmapped(un_c));

   ucs_decoder #(.REGISTERED(1'b1)) dut_reg (
      .clk(clk), .rst(rst), .addr(addr),
      .region_sel(sel_r), .offset(off_r), .unmapped(un_r));

   function automatic logic [2:0] exp_sel(input int a);
      if (a >= 'h6050 && a < 'h8050) return 3'b001;
      if (a >= 'h8050 && a < 'hA050) return 3'b010;
      if (a >= 'hA050 && a < 'hC050) return 3'b100;
      return 3'b000;
   endfunction

   function automatic logic [12:0] exp_off(input int a);
      if (a >= 'h6050 && a < 'h8050) return 13'((a - 'h6050) % 8192);
      if (a >= 'h8050 && a < 'hA050) return 13'((a - 'h8050) % 8192);
      if (a >= 'hA050 && a < 'hC050) return 13'((a - 'hA050) % 8192);
      return 13'd0;
   endfunction

   function automatic string req_of(input int a);
      logic [2:0] s;
      s = exp_sel(a);
      if (s[0]) return "R2";
      if (s[1]) return "R3";
      if (s[2]) return "R4";
      return "R5";
   endfunction

   task automatic check_comb(input int a, input string tag);
      logic [2:0]  es;
      logic [12:0] eo;
      es = exp_sel(a);
      eo = exp_off(a);
      checks++;
      if (sel_c !== es || un_c !== (es == 3'b000) || off_c !== eo) begin
         fails++;
         $display("FAIL %s addr=%h sel=%b/%b un=%b/%b off=%h/%h (actual/expected)",
                  tag, a[15:0], sel_c, es, un_c, (es == 3'b000), off_c, eo);
      end
   endtask

   task automatic check_reg(input int a, input string tag);
      logic [2:0]  es;
      logic [12:0] eo;
      es = exp_sel(a);
      eo = exp_off(a);
      checks++;
      if (sel_r !== es || un_r !== (es == 3'b000) || off_r !== eo) begin
         fails++;
         $display("FAIL %s reg addr=%h sel=%b/%b un=%b/%b off=%h/%h (actual/expected)",
                  tag, a[15:0], sel_r, es, un_r, (es == 3'b000), off_r, eo);
      end
   endtask

   initial begin
      #20000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int edges [8] = '{'h6050, 'h8050, 'hA050, 'hC050, 'h0000, 'hFFFF, 'h804F, 'hC04F};
      // reset state of the registered instance (R10)
      repeat (2) @(posedge clk);
      #2;
      checks++;
      if (sel_r !== 3'b000 || off_r !== 13'd0 || un_r !== 1'b1) begin
         fails++;
         $display("FAIL R10 reset sel=%b off=%h un=%b expected 000/0000/1", sel_r, off_r, un_r);
      end
      @(negedge clk) rst = 1'b0;

      // full sweep: combinational at once, registered one edge later (R2-R9)
      for (int a = 0; a < 65536; a++) begin
         addr = 16'(a);
         #1;
         check_comb(a, req_of(a));
         if (exp_sel(a) != 3'b000) check_comb(a, "R6");
         else check_comb(a, "R7");
         @(posedge clk);
         #2;
         check_reg(a, "R9");
         @(negedge clk);
      end

      // boundary neighbourhoods (R8, R1)
      foreach (edges[i]) begin
         for (int d = -1; d <= 1; d++) begin
            int a = edges[i] + d;
            if (a < 0 || a > 65535) continue;
            addr = 16'(a);
            #1;
            check_comb(a, "R8");
            checks++;
            if ($countones(sel_c) > 1) begin
               fails++;
               $display("FAIL R1 addr=%h sel=%b expected at most one bit", a[15:0], sel_c);
            end
            @(negedge clk);
         end
      end

      // reset with a mapped address in the pipeline (R10)
      addr = 16'h9000;
      @(posedge clk); #2;
      check_reg('h9000, "R9");
      @(negedge clk) rst = 1'b1;
      @(posedge clk); #2;
      checks++;
      if (sel_r !== 3'b000 || off_r !== 13'd0 || un_r !== 1'b1) begin
         fails++;
         $display("FAIL R10 sel=%b off=%h un=%b expected 000/0000/1", sel_r, off_r, un_r);
      end
      @(negedge clk) rst = 1'b0;
      @(posedge clk); #2;
      check_reg('h9000, "R10");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule